// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Macrocell

This block is one output cell of a programmable logic array. A single precomputed sum-of-products bit enters a storage stage. Static configuration sets that stage to one of four modes: combinational pass-through, edge-triggered D register, edge-triggered toggle register, or level-sensitive latch. The clock for the stage comes from one of the system clocks, and a configuration bit can invert it. Two asynchronous controls are shared across a logic block, a clear and a set, and both act on the stored value.

The stored value returns to the routing fabric as feedback. A polarity stage then drives the pad, and the pin cell chooses the pad's output enable from four modes: always driven, never driven, or following one of two bank enable terms. The pad's input path is separate from the feedback path. A cell whose output is used only internally therefore leaves its pad free to act as an input.

Configuration arrives as static inputs. The bench changes it only while the clear is held.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_store` = 2'b00 (combinational), `fb_out` equals `sop_in` at all times, and `blk_clear` and `blk_set` have no effect on it.
- R2: With `cfg_store` = 2'b01 (D register), `fb_out` takes the value of `sop_in` on each active edge of the selected clock and holds it between edges.
- R3: With `cfg_store` = 2'b10 (toggle register), `fb_out` inverts on an active clock edge when `sop_in` is 1 and holds when `sop_in` is 0.
- R4: With `cfg_store` = 2'b11 (latch), `fb_out` follows `sop_in` while the selected, polarity-adjusted clock is high, and holds the last value while that clock is low.
- R5: `cfg_clk_sel` is a binary index into `sys_clk`. Activity on the unselected clock lines does not change `fb_out`.
- R6: With `cfg_clk_inv` = 1, the active edge is the falling edge of the selected clock, and the latch is transparent while that clock is low.
- R7: In the three storing modes, `blk_clear` = 1 forces `fb_out` to 0 at once, without a clock. It wins when `blk_set` is also 1.
- R8: In the three storing modes, `blk_set` = 1 with `blk_clear` = 0 forces `fb_out` to 1 at once, without a clock.
- R9: `pad_out` equals `fb_out` when `cfg_out_inv` = 0 and its inverse when `cfg_out_inv` = 1. `cfg_out_inv` does not affect `fb_out`.
- R10: `pad_oe` is 1 for `cfg_oe_mode` = 2'b00, 0 for 2'b01, `oe_term[0]` for 2'b10 and `oe_term[1]` for 2'b11.
- R11: `pin_in` equals `pad_in` in every output-enable mode and every storage mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | NUM_CLKS | System clock lines |
| blk_clear | input | 1 | Block-wide asynchronous clear, active high |
| blk_set | input | 1 | Block-wide asynchronous set, active high |
| sop_in | input | 1 | Precomputed sum-of-products data bit |
| oe_term | input | 2 | Bank output-enable terms 0 and 1 |
| pad_in | input | 1 | Value seen at the pad |
| cfg_store | input | 2 | Storage mode (00 comb, 01 D, 10 toggle, 11 latch) |
| cfg_clk_sel | input | CLK_SEL_W | Index of the selected system clock |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_out_inv | input | 1 | Invert the value driven to the pad |
| cfg_oe_mode | input | 2 | Output-enable mode (00 on, 01 off, 10 term 0, 11 term 1) |
| pad_out | output | 1 | Data toward the pad driver |
| pad_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Stored value fed back to the routing fabric |
| pin_in | output | 1 | Pad input path toward the routing fabric |

## Verification
The bench builds the block with the default NUM_CLKS = 4. This reaches every clock index, so activity on three unselected lines can be set against edges on the chosen one. The bench sweeps all four storage modes against every clock index and both clock polarities. It pairs each combination with a different output-enable mode and output polarity. Random toggling of data, clocks, set pulses, enable terms and pad input then exercises each combination. The two-clock build narrows the select field to one bit and takes the other generate branch of the clock selector. The bench does not build that variant.

// File: rtl/mc_pkg.sv
package mc_pkg;

   typedef enum logic [1:0] {
      STORE_COMB  = 2'b00,
      STORE_D     = 2'b01,
      STORE_T     = 2'b10,
      STORE_LATCH = 2'b11
   } store_mode_e;

   typedef enum logic [1:0] {
      OE_ALWAYS_ON  = 2'b00,
      OE_ALWAYS_OFF = 2'b01,
      OE_BANK_TERM0 = 2'b10,
      OE_BANK_TERM1 = 2'b11
   } oe_mode_e;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mc_clock_sel.sv
module mc_clock_sel #(
   parameter int unsigned NUM_CLKS  = 4,
   parameter int unsigned CLK_SEL_W = mc_pkg::sel_width(NUM_CLKS)
) (
   input  logic [NUM_CLKS-1:0]  sys_clk,
   input  logic [CLK_SEL_W-1:0] sel,
   input  logic                 inv,
   output logic                 eff_clk
);

   logic picked;

   generate
      if (NUM_CLKS == 2) begin : g_two
         assign picked = sel[0] ? sys_clk[1] : sys_clk[0];
      end else begin : g_four
         always_comb begin
            case (sel)
               2'd0:    picked = sys_clk[0];
               2'd1:    picked = sys_clk[1];
               2'd2:    picked = sys_clk[2];
               default: picked = sys_clk[3];
            endcase
         end
      end
   endgenerate

   assign eff_clk = picked ^ inv;

endmodule

// File: rtl/mc_store.sv
module mc_store
   import mc_pkg::*;
(
   input  logic        eff_clk,
   input  store_mode_e mode,
   input  logic        d,
   input  logic        clr,
   input  logic        set,
   output logic        q
);

   logic ff_q;
   logic lat_q;

   always_ff @(posedge eff_clk or posedge clr or posedge set) begin
      if (clr) begin
         ff_q <= 1'b0;
      end else if (set) begin
         ff_q <= 1'b1;
      end else if (mode == STORE_D) begin
         ff_q <= d;
      end else if (mode == STORE_T) begin
         ff_q <= ff_q ^ d;
      end
   end

   always_latch begin
      if (clr) begin
         lat_q <= 1'b0;
      end else if (set) begin
         lat_q <= 1'b1;
      end else if (eff_clk && (mode == STORE_LATCH)) begin
         lat_q <= d;
      end
   end

   always_comb begin
      case (mode)
         STORE_COMB:  q = d;
         STORE_LATCH: q = lat_q;
         default:     q = ff_q;
      endcase
   end

endmodule

// File: rtl/mc_pin_cell.sv
module mc_pin_cell
   import mc_pkg::*;
(
   input  logic       q,
   input  logic       out_inv,
   input  oe_mode_e   oe_mode,
   input  logic [1:0] oe_term,
   input  logic       pad_in,
   output logic       pad_out,
   output logic       pad_oe,
   output logic       pin_in
);

   assign pad_out = out_inv ? ~q : q;

   always_comb begin
      case (oe_mode)
         OE_ALWAYS_ON:  pad_oe = 1'b1;
         OE_ALWAYS_OFF: pad_oe = 1'b0;
         OE_BANK_TERM0: pad_oe = oe_term[0];
         default:       pad_oe = oe_term[1];
      endcase
   end

   assign pin_in = pad_in;

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
   import mc_pkg::*;
#(
   parameter int unsigned NUM_CLKS  = 4,
   parameter int unsigned CLK_SEL_W = mc_pkg::sel_width(NUM_CLKS)
) (
   input  logic [NUM_CLKS-1:0]  sys_clk,
   input  logic                 blk_clear,
   input  logic                 blk_set,
   input  logic                 sop_in,
   input  logic [1:0]           oe_term,
   input  logic                 pad_in,
   input  logic [1:0]           cfg_store,
   input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
   input  logic                 cfg_clk_inv,
   input  logic                 cfg_out_inv,
   input  logic [1:0]           cfg_oe_mode,
   output logic                 pad_out,
   output logic                 pad_oe,
   output logic                 fb_out,
   output logic                 pin_in
);

   generate
      if (!(NUM_CLKS == 2 || NUM_CLKS == 4)) begin : g_bad_clks
         $error("pld_macrocell: NUM_CLKS must be 2 or 4");
      end
      if (CLK_SEL_W != mc_pkg::sel_width(NUM_CLKS)) begin : g_bad_selw
         $error("pld_macrocell: CLK_SEL_W must match NUM_CLKS");
      end
   endgenerate

   logic        eff_clk;
   logic        stored;
   store_mode_e store_mode;
   oe_mode_e    oe_mode;

   assign store_mode = store_mode_e'(cfg_store);
   assign oe_mode    = oe_mode_e'(cfg_oe_mode);

   mc_clock_sel #(
      .NUM_CLKS  (NUM_CLKS),
      .CLK_SEL_W (CLK_SEL_W)
   ) u_clk (
      .sys_clk (sys_clk),
      .sel     (cfg_clk_sel),
      .inv     (cfg_clk_inv),
      .eff_clk (eff_clk)
   );

   mc_store u_store (
      .eff_clk (eff_clk),
      .mode    (store_mode),
      .d       (sop_in),
      .clr     (blk_clear),
      .set     (blk_set),
      .q       (stored)
   );

   assign fb_out = stored;

   mc_pin_cell u_pin (
      .q       (stored),
      .out_inv (cfg_out_inv),
      .oe_mode (oe_mode),
      .oe_term (oe_term),
      .pad_in  (pad_in),
      .pad_out (pad_out),
      .pad_oe  (pad_oe),
      .pin_in  (pin_in)
   );

endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
   parameter int unsigned NUM_CLKS  = 4,
   parameter int unsigned CLK_SEL_W = 2
) (
   input logic [NUM_CLKS-1:0]  sys_clk,
   input logic                 blk_clear,
   input logic                 blk_set,
   input logic                 sop_in,
   input logic [1:0]           oe_term,
   input logic                 pad_in,
   input logic [1:0]           cfg_store,
   input logic [CLK_SEL_W-1:0] cfg_clk_sel,
   input logic                 cfg_clk_inv,
   input logic                 cfg_out_inv,
   input logic [1:0]           cfg_oe_mode,
   input logic                 pad_out,
   input logic                 pad_oe,
   input logic                 fb_out,
   input logic                 pin_in
);

   logic chk_clk;
   assign chk_clk = sys_clk[0];

   p_comb_follow_r1: assert property (@(posedge chk_clk) disable iff (blk_clear)
      (cfg_store == 2'b00) |-> (fb_out == sop_in));

   p_clear_wins_r7: assert property (@(posedge chk_clk) disable iff (cfg_store == 2'b00)
      blk_clear |-> (fb_out == 1'b0));

   p_set_forces_r8: assert property (@(posedge chk_clk) disable iff (cfg_store == 2'b00)
      (blk_set && !blk_clear) |-> (fb_out == 1'b1));

   p_polarity_r9: assert property (@(posedge chk_clk) disable iff (blk_clear)
      pad_out == (fb_out ^ cfg_out_inv));

   p_oe_on_r10: assert property (@(posedge chk_clk) disable iff (blk_clear)
      (cfg_oe_mode == 2'b00) |-> pad_oe);

   p_oe_off_r10: assert property (@(posedge chk_clk) disable iff (blk_clear)
      (cfg_oe_mode == 2'b01) |-> !pad_oe);

   p_oe_term0_r10: assert property (@(posedge chk_clk) disable iff (blk_clear)
      (cfg_oe_mode == 2'b10) |-> (pad_oe == oe_term[0]));

   p_oe_term1_r10: assert property (@(posedge chk_clk) disable iff (blk_clear)
      (cfg_oe_mode == 2'b11) |-> (pad_oe == oe_term[1]));

   p_pad_path_r11: assert property (@(posedge chk_clk) disable iff (blk_clear)
      pin_in == pad_in);

endmodule

bind pld_macrocell pld_macrocell_chk #(
   .NUM_CLKS  (NUM_CLKS),
   .CLK_SEL_W (CLK_SEL_W)
) u_chk (
   .sys_clk     (sys_clk),
   .blk_clear   (blk_clear),
   .blk_set     (blk_set),
   .sop_in      (sop_in),
   .oe_term     (oe_term),
   .pad_in      (pad_in),
   .cfg_store   (cfg_store),
   .cfg_clk_sel (cfg_clk_sel),
   .cfg_clk_inv (cfg_clk_inv),
   .cfg_out_inv (cfg_out_inv),
   .cfg_oe_mode (cfg_oe_mode),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .fb_out      (fb_out),
   .pin_in      (pin_in)
);

// File: tb/test_pld_macrocell.sv
module test_pld_macrocell;

   logic       clk = 1'b0;
   logic [3:0] sys_clk = 4'b0000;
   logic       blk_clear = 1'b1;
   logic       blk_set = 1'b0;
   logic       sop_in = 1'b0;
   logic [1:0] oe_term = 2'b00;
   logic       pad_in = 1'b0;
   logic [1:0] cfg_store = 2'b01;
   logic [1:0] cfg_clk_sel = 2'd0;
   logic       cfg_clk_inv = 1'b0;
   logic       cfg_out_inv = 1'b0;
   logic [1:0] cfg_oe_mode = 2'b00;
   logic       pad_out, pad_oe, fb_out, pin_in;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cyc = 0;
   bit    run = 1'b0;
   bit    done = 1'b0;
   string fb_tag = "R7 reset state";

   // behavioural reference state
   bit m_q = 1'b0;
   bit m_prev = 1'b0;

   always #10 clk = ~clk;

   pld_macrocell i_pld_macrocell (
      .sys_clk     (sys_clk),
      .blk_clear   (blk_clear),
      .blk_set     (blk_set),
      .sop_in      (sop_in),
      .oe_term     (oe_term),
      .pad_in      (pad_in),
      .cfg_store   (cfg_store),
      .cfg_clk_sel (cfg_clk_sel),
      .cfg_clk_inv (cfg_clk_inv),
      .cfg_out_inv (cfg_out_inv),
      .cfg_oe_mode (cfg_oe_mode),
      .pad_out     (pad_out),
      .pad_oe      (pad_oe),
      .fb_out      (fb_out),
      .pin_in      (pin_in)
   );

   task automatic model_step();
      bit eff;
      eff = sys_clk[cfg_clk_sel] ^ cfg_clk_inv;
      if (blk_clear) m_q = 1'b0;
      else if (blk_set) m_q = 1'b1;
      else begin
         if (cfg_store == 2'b01 && eff && !m_prev) m_q = sop_in;
         if (cfg_store == 2'b10 && eff && !m_prev) m_q = m_q ^ sop_in;
         if (cfg_store == 2'b11 && eff) m_q = sop_in;
      end
      m_prev = eff;
   endtask

   function automatic bit exp_fb();
      return (cfg_store == 2'b00) ? sop_in : m_q;
   endfunction

   function automatic bit exp_oe();
      case (cfg_oe_mode)
         2'b00:   return 1'b1;
         2'b01:   return 1'b0;
         2'b10:   return oe_term[0];
         default: return oe_term[1];
      endcase
   endfunction

   task automatic check1(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (run && !done) begin
         check1(fb_out, exp_fb(), fb_tag);
         check1(pad_out, exp_fb() ^ cfg_out_inv, "R9 output polarity");
         check1(pad_oe, exp_oe(), "R10 output enable mode");
         check1(pin_in, pad_in, "R11 pad input path");
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic ctl(input logic clr, input logic set);
      @(negedge clk);
      blk_clear = clr;
      blk_set = set;
      model_step();
   endtask

   task automatic set_cfg(input logic [1:0] st, input logic [1:0] sel, input logic inv,
                          input logic oinv, input logic [1:0] oem);
      ctl(1'b1, 1'b0);
      @(negedge clk);
      cfg_store = st;
      cfg_clk_sel = sel;
      cfg_clk_inv = inv;
      cfg_out_inv = oinv;
      cfg_oe_mode = oem;
      model_step();
      ctl(1'b0, 1'b0);
   endtask

   task automatic rand_step();
      int r;
      r = int'($urandom % 8);
      @(negedge clk);
      if (r < 3) sop_in = ~sop_in;
      else if (r < 6) begin
         int k;
         k = int'($urandom % 4);
         sys_clk[k] = ~sys_clk[k];
      end else if (r == 6) begin
         oe_term = 2'($urandom);
         pad_in = ~pad_in;
      end else blk_set = ~blk_set;
      model_step();
   endtask

   initial begin
      model_step();
      @(negedge clk);
      run = 1'b1;
      // R7: reset state, then clear dominating over set
      ctl(1'b1, 1'b0);
      fb_tag = "R8 set forces one";
      ctl(1'b0, 1'b1);
      fb_tag = "R7 clear wins over set";
      ctl(1'b1, 1'b1);
      ctl(1'b1, 1'b0);
      ctl(1'b0, 1'b0);
      // R1: comb mode ignores clear and set
      set_cfg(2'b00, 2'd0, 1'b0, 1'b0, 2'b01);
      fb_tag = "R1 comb ignores clear/set";
      @(negedge clk); sop_in = 1'b1; model_step();
      ctl(1'b1, 1'b0);
      ctl(1'b0, 1'b1);
      ctl(1'b0, 1'b0);
      // sweep: every mode x clock index x polarity
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
               set_cfg(2'(m), 2'(s), v[0], v[0] ^ s[0], 2'(s + m));
               case (m)
                  0: fb_tag = "R1 comb follow (R5 sel, R6 inv, R8 set)";
                  1: fb_tag = "R2 D capture (R5 sel, R6 inv, R8 set)";
                  2: fb_tag = "R3 toggle (R5 sel, R6 inv, R8 set)";
                  default: fb_tag = "R4 latch (R5 sel, R6 inv, R8 set)";
               endcase
               if (blk_set) ctl(1'b0, 1'b0);
               for (int i = 0; i < 48; i++) rand_step();
               if (blk_set) ctl(1'b0, 1'b0);
               fb_tag = "R7 clear during reconfiguration";
            end
         end
      end
      @(negedge clk);
      finish_run();
   end

endmodule